// File: doc/BRIEF.md
# Segment Register Load Protection Checker

This block decides whether a segment register load may proceed. A request carries the target register, the 16-bit selector and the access-rights byte and table limit of the descriptor that was already fetched for it. The block checks these against the current privilege level and then does one of two things. It commits the selector and descriptor into a shadow bank that keeps one entry per register, or it reports a fault class together with its error code. A mode flag bypasses all checks for real-address and virtual-8086 operation, where the selector is simply stored.

The stack register and the four data registers follow separate rule sets. The stack register refuses a null selector and requires exact privilege equality. A data register accepts a null selector, which clears its hidden valid bit. Non-null data loads are judged with a privilege test that exempts conforming code. An access-check port lets later memory references through a data register learn whether that register holds a null selector, in which case they must fault.

Top module: `seg_load_guard`

## Requirements
- R1: During and after a synchronous active-high reset, every shadow selector, attribute byte and valid bit is zero, and `fault_vld_o`, `commit_o` and `acc_fault_o` are low.
- R2: Register codes are SS=0, DS=1, ES=2, FS=3, GS=4. A request with a code from 0 to 4 produces exactly one of `fault_vld_o` or `commit_o`, one cycle after the request. A cycle with no request, or with a code from 5 to 7, produces neither and changes no shadow state.
- R3: When `legacy_mode_i` is high, a request always commits. The full selector and the attribute byte are stored as given, and the valid bit is set, for every register including SS.
- R4: A selector is null when bits 15:2 are zero, so RPL in bits 1:0 is ignored. A null selector loaded into SS faults with class GP0 (`fault_cls_o`=1) and error code 0. Class codes are NONE=0, GP0=1, GPSEL=2, NP=3.
- R5: A non-null SS load faults with class GPSEL and error code {selector[15:2],2'b00} if any of the following holds: index*8+7 exceeds the table limit, RPL differs from CPL, DPL differs from CPL, or the segment is not a writable data segment. The attribute byte is {present[7], dpl[6:5], s[4], type[3:0]}. Type bit 3 marks code, bit 1 means writable for data or readable for code, and bit 2 marks conforming code.
- R6: For SS, the present bit is not examined. A not-present segment that passes R5 commits.
- R7: A non-null DS/ES/FS/GS load faults with GPSEL if the index is beyond the table limit, or if the segment is neither data (s=1, type bit 3 clear) nor readable code.
- R8: A non-null DS/ES/FS/GS load of data or nonconforming code faults with GPSEL when both RPL and CPL exceed DPL. Conforming code is exempt, and a load where only one of RPL or CPL exceeds DPL passes.
- R9: A DS/ES/FS/GS load that passes R7 and R8 but has the present bit clear faults with class NP and error code {selector[15:2],2'b00}.
- R10: A null selector loaded into DS/ES/FS/GS commits without a fault. The selector is stored and the register's valid bit is cleared.
- R11: A successful non-null load stores the full selector and attribute byte and sets the register's valid bit.
- R12: A faulting load leaves every shadow entry unchanged.
- R13: An access check (`acc_vld_i` with a code from 1 to 4) raises `acc_fault_o` one cycle later when that register's valid bit is clear at the request. Checks on code 0 or codes 5 to 7 never fault.
- R14: When several checks fail, the earliest in the order table limit, type, privilege, present decides the class. For example, a table-limit failure on a not-present segment reports GPSEL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Load request strobe |
| req_reg_i | input | 3 | Target register code |
| req_sel_i | input | 16 | Selector to load |
| req_attr_i | input | 8 | Descriptor attribute byte {present, dpl, s, type} |
| tbl_limit_i | input | LIMIT_W | Descriptor table limit in bytes |
| cpl_i | input | 2 | Current privilege level |
| legacy_mode_i | input | 1 | Real-address or virtual-8086 operation |
| acc_vld_i | input | 1 | Memory access check strobe |
| acc_reg_i | input | 3 | Register used by the access |
| fault_vld_o | output | 1 | Load fault strobe |
| fault_cls_o | output | 2 | Fault class |
| fault_code_o | output | 16 | Error code of the fault |
| commit_o | output | 1 | Load committed strobe |
| acc_fault_o | output | 1 | Access through a null data register |
| desc_valid_o | output | NSEG | Hidden valid bit per register |
| seg_sel_o | output | NSEG*16 | Stored selectors, register n at bits 16n+15:16n |
| seg_attr_o | output | NSEG*8 | Stored attribute bytes, register n at bits 8n+7:8n |

## Verification
All outcomes of a load (strobes, class, error code and the updated shadow bank) and the access-check result appear exactly one clock after the cycle that carried the stimulus. The bench's reference model updates on that same rising edge from the inputs held since the previous falling phase. All outputs are compared one nanosecond after the edge, before the next stimulus is driven, so every comparison lines up with the cycle the result is due. Shadow state is compared on every clock, which also confirms that idle cycles, faults and out-of-range codes leave it untouched.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;
  localparam int NSEG_DEF = 5;
  localparam int REG_W    = 3;

  typedef enum logic [REG_W-1:0] {
    SEG_SS = 3'd0,
    SEG_DS = 3'd1,
    SEG_ES = 3'd2,
    SEG_FS = 3'd3,
    SEG_GS = 3'd4
  } seg_id_e;

  typedef enum logic [1:0] {
    FC_NONE  = 2'd0,
    FC_GP0   = 2'd1,
    FC_GPSEL = 2'd2,
    FC_NP    = 2'd3
  } fault_cls_e;

  typedef struct packed {
    logic       present;
    logic [1:0] dpl;
    logic       s;
    logic [3:0] typ;
  } seg_attr_t;
endpackage

// File: rtl/seg_sel_split.sv
module seg_sel_split (
  input  logic [15:0] sel_i,
  output logic [12:0] idx_o,
  output logic        ti_o,
  output logic [1:0]  rpl_o,
  output logic        null_o
);
  assign idx_o  = sel_i[15:3];
  assign ti_o   = sel_i[2];
  assign rpl_o  = sel_i[1:0];
  assign null_o = (sel_i[15:2] == 14'd0);
endmodule

// File: rtl/seg_rule_eval.sv
module seg_rule_eval
  import seg_guard_pkg::*;
#(
  parameter int LIMIT_W = 16
) (
  input  logic [REG_W-1:0]   reg_i,
  input  logic [15:0]        sel_i,
  input  logic [12:0]        idx_i,
  input  logic [1:0]         rpl_i,
  input  logic               null_i,
  input  seg_attr_t          attr_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic [1:0]         cpl_i,
  input  logic               legacy_i,
  output fault_cls_e         cls_o,
  output logic [15:0]        code_o,
  output logic               new_valid_o
);
  localparam int CMP_W = (LIMIT_W > 16) ? LIMIT_W : 16;

  logic [CMP_W-1:0] last_byte;
  logic [CMP_W-1:0] lim_ext;
  logic             lim_bad;
  logic             is_code;
  logic             rw_bit;
  logic             conform;
  logic             ss_type_ok;
  logic             ds_type_ok;
  logic             ds_priv_bad;

  assign last_byte   = CMP_W'({idx_i, 3'b111});
  assign lim_ext     = CMP_W'(limit_i);
  assign lim_bad     = last_byte > lim_ext;
  assign is_code     = attr_i.typ[3];
  assign rw_bit      = attr_i.typ[1];
  assign conform     = is_code && attr_i.typ[2];
  assign ss_type_ok  = attr_i.s && !is_code && rw_bit;
  assign ds_type_ok  = attr_i.s && (!is_code || rw_bit);
  assign ds_priv_bad = !conform && (rpl_i > attr_i.dpl) && (cpl_i > attr_i.dpl);

  always_comb begin
    cls_o       = FC_NONE;
    new_valid_o = 1'b1;
    if (legacy_i) begin
      cls_o = FC_NONE;
    end else if (reg_i == SEG_SS) begin
      if (null_i)
        cls_o = FC_GP0;
      else if (lim_bad || (rpl_i != cpl_i) || !ss_type_ok || (attr_i.dpl != cpl_i))
        cls_o = FC_GPSEL;
    end else begin
      if (null_i)
        new_valid_o = 1'b0;
      else if (lim_bad || !ds_type_ok || ds_priv_bad)
        cls_o = FC_GPSEL;
      else if (!attr_i.present)
        cls_o = FC_NP;
    end
  end

  assign code_o = ((cls_o == FC_GPSEL) || (cls_o == FC_NP)) ? {sel_i[15:2], 2'b00} : 16'd0;
endmodule

// File: rtl/seg_shadow_bank.sv
module seg_shadow_bank
  import seg_guard_pkg::*;
#(
  parameter int NSEG = NSEG_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_idx_i,
  input  logic [15:0]       wr_sel_i,
  input  logic [7:0]        wr_attr_i,
  input  logic              wr_valid_i,
  output logic [NSEG-1:0]   valid_o,
  output logic [NSEG*16-1:0] sel_o,
  output logic [NSEG*8-1:0]  attr_o
);
  for (genvar g = 0; g < NSEG; g++) begin : g_entry
    logic [15:0] sel_q;
    logic [7:0]  attr_q;
    logic        vld_q;
    logic        hit;

    assign hit = wr_en_i && (wr_idx_i == REG_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q  <= '0;
        attr_q <= '0;
        vld_q  <= 1'b0;
      end else if (hit) begin
        sel_q  <= wr_sel_i;
        attr_q <= wr_attr_i;
        vld_q  <= wr_valid_i;
      end
    end

    assign valid_o[g]           = vld_q;
    assign sel_o[g*16 +: 16]    = sel_q;
    assign attr_o[g*8 +: 8]     = attr_q;
  end
endmodule

// File: rtl/seg_load_guard.sv
module seg_load_guard
  import seg_guard_pkg::*;
#(
  parameter int NSEG    = NSEG_DEF,
  parameter int LIMIT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid_i,
  input  logic [2:0]          req_reg_i,
  input  logic [15:0]         req_sel_i,
  input  logic [7:0]          req_attr_i,
  input  logic [LIMIT_W-1:0]  tbl_limit_i,
  input  logic [1:0]          cpl_i,
  input  logic                legacy_mode_i,
  input  logic                acc_vld_i,
  input  logic [2:0]          acc_reg_i,
  output logic                fault_vld_o,
  output logic [1:0]          fault_cls_o,
  output logic [15:0]         fault_code_o,
  output logic                commit_o,
  output logic                acc_fault_o,
  output logic [NSEG-1:0]     desc_valid_o,
  output logic [NSEG*16-1:0]  seg_sel_o,
  output logic [NSEG*8-1:0]   seg_attr_o
);
  logic [12:0] idx;
  logic        ti_unused;
  logic [1:0]  rpl;
  logic        sel_null;
  fault_cls_e  cls;
  logic [15:0] code;
  logic        new_valid;
  logic        req_ok;
  logic        wr_en;
  logic        acc_hit;

  seg_sel_split u_split (
    .sel_i  (req_sel_i),
    .idx_o  (idx),
    .ti_o   (ti_unused),
    .rpl_o  (rpl),
    .null_o (sel_null)
  );

  seg_rule_eval #(.LIMIT_W(LIMIT_W)) u_rules (
    .reg_i       (req_reg_i),
    .sel_i       (req_sel_i),
    .idx_i       (idx),
    .rpl_i       (rpl),
    .null_i      (sel_null),
    .attr_i      (seg_attr_t'(req_attr_i)),
    .limit_i     (tbl_limit_i),
    .cpl_i       (cpl_i),
    .legacy_i    (legacy_mode_i),
    .cls_o       (cls),
    .code_o      (code),
    .new_valid_o (new_valid)
  );

  assign req_ok = req_valid_i && (req_reg_i < REG_W'(NSEG));
  assign wr_en  = req_ok && (cls == FC_NONE);

  seg_shadow_bank #(.NSEG(NSEG)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en),
    .wr_idx_i   (req_reg_i),
    .wr_sel_i   (req_sel_i),
    .wr_attr_i  (req_attr_i),
    .wr_valid_i (new_valid),
    .valid_o    (desc_valid_o),
    .sel_o      (seg_sel_o),
    .attr_o     (seg_attr_o)
  );

  always_comb begin
    acc_hit = 1'b0;
    for (int i = 1; i < NSEG; i++)
      if (acc_reg_i == REG_W'(i) && !desc_valid_o[i])
        acc_hit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_vld_o  <= 1'b0;
      fault_cls_o  <= FC_NONE;
      fault_code_o <= '0;
      commit_o     <= 1'b0;
      acc_fault_o  <= 1'b0;
    end else begin
      fault_vld_o  <= req_ok && (cls != FC_NONE);
      commit_o     <= wr_en;
      fault_cls_o  <= req_ok ? cls : FC_NONE;
      fault_code_o <= req_ok ? code : 16'd0;
      acc_fault_o  <= acc_vld_i && acc_hit;
    end
  end

  logic unused_ok;
  assign unused_ok = ti_unused;
endmodule

// File: rtl/seg_load_guard_chk.sv
module seg_load_guard_chk #(
  parameter int NSEG = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid_i,
  input logic [2:0]         req_reg_i,
  input logic [15:0]        req_sel_i,
  input logic               legacy_mode_i,
  input logic               acc_vld_i,
  input logic [2:0]         acc_reg_i,
  input logic               fault_vld_o,
  input logic [1:0]         fault_cls_o,
  input logic [15:0]        fault_code_o,
  input logic               commit_o,
  input logic               acc_fault_o,
  input logic [NSEG-1:0]    desc_valid_o,
  input logic [NSEG*16-1:0] seg_sel_o
);
  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_reg_i < 3'(NSEG)) |=> (fault_vld_o ^ commit_o));

  // R2
  quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid_i && req_reg_i < 3'(NSEG)) |=> (!fault_vld_o && !commit_o && $stable(seg_sel_o)));

  // R3
  legacy_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_reg_i < 3'(NSEG) && legacy_mode_i) |=> commit_o);

  // R4
  ss_null_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_reg_i == 3'd0 && !legacy_mode_i && req_sel_i[15:2] == 14'd0)
      |=> (fault_vld_o && fault_cls_o == 2'd1 && fault_code_o == 16'd0));

  // R10
  data_null_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_reg_i != 3'd0 && req_reg_i < 3'(NSEG) && !legacy_mode_i
      && req_sel_i[15:2] == 14'd0) |=> (commit_o && !desc_valid_o[$past(req_reg_i)]));

  // R12
  fault_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    fault_vld_o |-> $stable(seg_sel_o));

  // R13
  null_access_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_vld_i && acc_reg_i != 3'd0 && acc_reg_i < 3'(NSEG) && !desc_valid_o[acc_reg_i])
      |=> acc_fault_o);

  // R13
  ss_access_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_reg_i == 3'd0 || !acc_vld_i) |=> !acc_fault_o);
endmodule

bind seg_load_guard seg_load_guard_chk #(.NSEG(NSEG)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .req_valid_i   (req_valid_i),
  .req_reg_i     (req_reg_i),
  .req_sel_i     (req_sel_i),
  .legacy_mode_i (legacy_mode_i),
  .acc_vld_i     (acc_vld_i),
  .acc_reg_i     (acc_reg_i),
  .fault_vld_o   (fault_vld_o),
  .fault_cls_o   (fault_cls_o),
  .fault_code_o  (fault_code_o),
  .commit_o      (commit_o),
  .acc_fault_o   (acc_fault_o),
  .desc_valid_o  (desc_valid_o),
  .seg_sel_o     (seg_sel_o)
);

// File: tb/seg_load_guard_tb_top.sv
`timescale 1ns/1ps
module seg_load_guard_tb_top;
  localparam int NSEG = 5;
  localparam int LW   = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid_i;
  logic [2:0]        req_reg_i;
  logic [15:0]       req_sel_i;
  logic [7:0]        req_attr_i;
  logic [LW-1:0]     tbl_limit_i;
  logic [1:0]        cpl_i;
  logic              legacy_mode_i;
  logic              acc_vld_i;
  logic [2:0]        acc_reg_i;
  logic              fault_vld_o;
  logic [1:0]        fault_cls_o;
  logic [15:0]       fault_code_o;
  logic              commit_o;
  logic              acc_fault_o;
  logic [NSEG-1:0]   desc_valid_o;
  logic [NSEG*16-1:0] seg_sel_o;
  logic [NSEG*8-1:0]  seg_attr_o;

  always #2 clk = ~clk;

  seg_load_guard #(.NSEG(NSEG), .LIMIT_W(LW)) dut_i (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  string tag = "R1";

  // reference state
  logic [15:0] m_sel  [NSEG];
  logic [7:0]  m_attr [NSEG];
  bit          m_vld  [NSEG];
  bit          e_fv, e_cm, e_af;
  int          e_cls;
  logic [15:0] e_code;

  task automatic check(string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int judge(int r, logic [15:0] s, logic [7:0] a, int lim, int cpl, bit leg,
                               output bit nv);
    int  idx = s >> 3;
    int  rpl = s & 3;
    int  dpl = (a >> 5) & 3;
    bit  sys = a[4];
    bit  cd  = a[3];
    bit  conf = a[3] & a[2];
    bit  rw  = a[1];
    bit  pr  = a[7];
    bit  nul = (s >> 2) == 0;
    bit  too_far = (idx * 8 + 7) > lim;
    nv = 1;
    if (leg) return 0;
    if (r == 0) begin
      if (nul) return 1;
      if (too_far) return 2;
      if (rpl != cpl) return 2;
      if (!(sys && !cd && rw)) return 2;
      if (dpl != cpl) return 2;
      return 0;
    end
    if (nul) begin nv = 0; return 0; end
    if (too_far) return 2;
    if (!sys) return 2;
    if (cd && !rw) return 2;
    if (!conf && rpl > dpl && cpl > dpl) return 2;
    if (!pr) return 3;
    return 0;
  endfunction

  task automatic tick();
    bit ok, nv;
    int c;
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < NSEG; i++) begin m_sel[i] = 0; m_attr[i] = 0; m_vld[i] = 0; end
      e_fv = 0; e_cm = 0; e_af = 0; e_cls = 0; e_code = 0;
    end else begin
      e_af = acc_vld_i && acc_reg_i >= 1 && acc_reg_i < NSEG && !m_vld[acc_reg_i];
      ok = req_valid_i && req_reg_i < NSEG;
      c  = judge(int'(req_reg_i), req_sel_i, req_attr_i, int'(tbl_limit_i), int'(cpl_i),
                 legacy_mode_i, nv);
      e_fv = ok && c != 0;
      e_cm = ok && c == 0;
      e_cls = ok ? c : 0;
      e_code = (ok && c >= 2) ? (req_sel_i & 16'hFFFC) : 16'h0;
      if (e_cm) begin
        m_sel[req_reg_i] = req_sel_i;
        m_attr[req_reg_i] = req_attr_i;
        m_vld[req_reg_i] = nv;
      end
    end
    #1;
    check("fault_vld", fault_vld_o, e_fv);
    check("commit", commit_o, e_cm);
    check("fault_cls", fault_cls_o, e_cls);
    check("fault_code", fault_code_o, e_code);
    check("acc_fault", acc_fault_o, e_af);
    for (int i = 0; i < NSEG; i++) begin
      check("seg_sel", seg_sel_o[i*16 +: 16], m_sel[i]);
      check("seg_attr", seg_attr_o[i*8 +: 8], m_attr[i]);
      check("desc_valid", desc_valid_o[i], m_vld[i]);
    end
  endtask

  task automatic load(int r, logic [15:0] s, logic [7:0] a, int lim, int cpl, bit leg);
    req_valid_i = 1; req_reg_i = 3'(r); req_sel_i = s; req_attr_i = a;
    tbl_limit_i = LW'(lim); cpl_i = 2'(cpl); legacy_mode_i = leg;
    tick();
    req_valid_i = 0;
  endtask

  task automatic expect_cls(int cls);
    check("class", fault_cls_o, cls);
  endtask

  task automatic probe(int r);
    acc_vld_i = 1; acc_reg_i = 3'(r);
    tick();
    acc_vld_i = 0;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; req_valid_i = 0; req_reg_i = 0; req_sel_i = 0; req_attr_i = 0;
    tbl_limit_i = 16'h00FF; cpl_i = 0; legacy_mode_i = 0; acc_vld_i = 0; acc_reg_i = 0;
    tag = "R1"; tick(); tick();
    rst = 0; tick();

    tag = "R13"; probe(1); check("acc null DS", acc_fault_o, 1); probe(0); probe(6);

    tag = "R4";  load(0, 16'h0003, 8'h92, 255, 3, 0); expect_cls(1);
    tag = "R5";  load(0, 16'h0200, 8'h92, 255, 0, 0); expect_cls(2);   // beyond limit
    load(0, 16'h0011, 8'h92, 255, 0, 0); expect_cls(2);                 // rpl != cpl
    load(0, 16'h0010, 8'h90, 255, 0, 0); expect_cls(2);                 // read-only data
    load(0, 16'h0010, 8'h9A, 255, 0, 0); expect_cls(2);                 // code
    load(0, 16'h0013, 8'h92, 255, 3, 0); expect_cls(2);                 // dpl != cpl
    load(0, 16'h0013, 8'hF2, 255, 3, 0); expect_cls(0);
    tag = "R6";  load(0, 16'h0018, 8'h12, 255, 0, 0); check("ss np commit", commit_o, 1);
    tag = "R7";  load(1, 16'h0100, 8'h92, 255, 0, 0); expect_cls(2);
    load(2, 16'h0020, 8'h82, 255, 0, 0); expect_cls(2);                 // system
    load(3, 16'h0020, 8'h98, 255, 0, 0); expect_cls(2);                 // execute only
    tag = "R8";  load(1, 16'h0023, 8'h92, 255, 3, 0); expect_cls(2);
    load(1, 16'h0023, 8'h9E, 255, 3, 0); expect_cls(0);                 // conforming
    load(2, 16'h0023, 8'h92, 255, 0, 0); expect_cls(0);                 // only rpl high
    load(3, 16'h0020, 8'h9A, 255, 3, 0); expect_cls(0);                 // only cpl high
    tag = "R9";  load(4, 16'h0028, 8'h12, 255, 0, 0); expect_cls(3);
    check("np code", fault_code_o, 16'h0028);
    tag = "R14"; load(4, 16'h0800, 8'h12, 255, 0, 0); expect_cls(2);
    load(4, 16'h002B, 8'h02, 255, 3, 0); expect_cls(2);
    tag = "R11"; load(4, 16'h002B, 8'hF2, 255, 3, 0); check("gs valid", desc_valid_o[4], 1);
    tag = "R13"; probe(4); check("acc valid GS", acc_fault_o, 0);
    tag = "R12"; load(4, 16'h0800, 8'h92, 255, 0, 0); check("kept", seg_sel_o[64 +: 16], 16'h002B);
    tag = "R10"; load(4, 16'h0002, 8'h00, 0, 0, 0); check("gs null", desc_valid_o[4], 0);
    tag = "R13"; probe(4); check("acc null GS", acc_fault_o, 1);
    tag = "R3";  load(0, 16'h0000, 8'h00, 0, 0, 1); check("legacy ss", desc_valid_o[0], 1);
    load(2, 16'hFFFF, 8'h00, 0, 2, 1); check("legacy es", seg_sel_o[32 +: 16], 16'hFFFF);
    tag = "R2";  load(6, 16'h0010, 8'h92, 255, 0, 0); check("bad code", commit_o | fault_vld_o, 0);
    tick();

    tag = "R2";
    for (int k = 0; k < 2000; k++) begin
      req_valid_i = 1'($urandom_range(0, 3) != 0);
      req_reg_i = 3'($urandom_range(0, 7));
      req_sel_i = 16'($urandom_range(0, 16'h00FF));
      req_attr_i = 8'($urandom);
      tbl_limit_i = LW'($urandom_range(0, 255));
      cpl_i = 2'($urandom);
      legacy_mode_i = 1'($urandom_range(0, 7) == 0);
      acc_vld_i = 1'($urandom);
      acc_reg_i = 3'($urandom_range(0, 7));
      tick();
    end
    req_valid_i = 0; acc_vld_i = 0;
    tick();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule